// File: doc/BRIEF.md
# Bus Breakpoint Comparator Unit

This unit sits beside a CPU bus and watches, on every cycle, the 16-bit address, an 8-bit extended page value, the 8-bit data bus and the read/write line. When one of its armed comparators sees a matching bus cycle, it raises a break request. The request goes to one of two outputs. One asks the core to enter background-debug mode. The other asks for a software interrupt.

Comparators A and B form a pair. In dual mode, each of them matches its own address. In full mode, A matches the address, B matches the data bus, and a break needs both to match in the same bus cycle. Comparator C is a third breakpoint. It compares all 16 address bits. It can also require a particular read/write level. With its page compare switched on, it also checks the extended page value. C is usable when the A/B pair is enabled, and also when trace capture is enabled outside loop-capture mode. Arming trace capture in loop-capture mode clears C's address value.

Software sets the unit up through a byte-wide register write port. Each break is a single-cycle pulse, and a bus cycle that stays on the same address is not reported twice.

Top module: `brk_unit`

## Requirements
- R1: Register 0 bit 0 is the A/B enable. While it is 0, comparators A and B never cause a break, whatever the full-mode bit (register 0 bit 1) holds.
- R2: With register 0 bit 0 = 1 and bit 1 = 0 (dual mode), a valid bus cycle whose address equals comparator A (registers 6 high byte, 7 low byte) or comparator B (registers 8 high, 9 low) causes a break.
- R3: With register 0 bits 1:0 = 11 (full mode), a break needs two things in the same bus cycle: the address equals comparator A, and the data bus equals the B data byte (register 10). B's address registers are then ignored.
- R4: Register 0 bit 2 routes breaks. A 0 pulses brkSwi and a 1 pulses brkDbg. The two outputs are never high together.
- R5: Register 1 bit 0 is the trace enable and bit 1 is the loop-capture mode. A write that tries to change the trace enable while the A/B enable is 1 leaves it unchanged. The loop bit of the same write still takes effect.
- R6: Register 2 bit 0 enables comparator C. C compares all 16 address bits against registers 3 (high) and 4 (low). C is active when the A/B enable is 1, or when the trace enable is 1 and loop-capture mode is 0.
- R7: Register 2 bit 3 is C's page compare. When it is 1, busPage[7:2] must equal the 6-bit extension value (register 5). C's high byte is then compared against {busPage[1:0], busAddr[13:8]} instead of busAddr[15:8].
- R8: Register 2 bit 1 enables C's read/write qualification and bit 2 is the required level. When the qualification is enabled, a C match also needs busRw to equal that level.
- R9: A write to register 1 that leaves the trace enable at 1 and loop-capture mode at 1 clears C's 16-bit address value to zero. This happens only when the A/B enable is 0.
- R10: Comparisons happen only when busValid is 1. A match pulses the routed output for one cycle, in the clock after the matching bus cycle. A match is not reported again while consecutive valid matching cycles keep the same address.
- R11: After reset, all registers are zero, both outputs are low, and no bus cycle causes a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWdata | input | 8 | Register write data |
| busValid | input | 1 | Bus cycle valid |
| busAddr | input | 16 | Bus address |
| busPage | input | 8 | Extended address bits 21:14 |
| busData | input | 8 | Bus data |
| busRw | input | 1 | Read/write level (1 = read) |
| brkSwi | output | 1 | Software-interrupt break pulse |
| brkDbg | output | 1 | Debug-mode entry break pulse |

## Verification
A control bit held in the wrong state shows at the ports in one of two ways: a pulse on the wrong line, or a pulse that is missing in the clock after the next bus cycle the bit governs. A wrong trace-enable state or a stale C value can stay hidden until comparator C is exercised in debug mode. For that reason the bench brings those states out through C matches right after each control write. If the held-hit tracking is corrupted, the effect appears within one cycle: a repeated pulse on a steady address, or a missing pulse on a new one. The reference model is compared on every clock, so a divergence is reported at the cycle it appears.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 8;
  localparam int EXT_W  = PAGE_W - 2;
  localparam int REG_AW = 4;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] OFS_AB    = 4'd0;
  localparam logic [REG_AW-1:0] OFS_DBG   = 4'd1;
  localparam logic [REG_AW-1:0] OFS_CCTL  = 4'd2;
  localparam logic [REG_AW-1:0] OFS_CHI   = 4'd3;
  localparam logic [REG_AW-1:0] OFS_CLO   = 4'd4;
  localparam logic [REG_AW-1:0] OFS_CEXT  = 4'd5;
  localparam logic [REG_AW-1:0] OFS_AHI   = 4'd6;
  localparam logic [REG_AW-1:0] OFS_ALO   = 4'd7;
  localparam logic [REG_AW-1:0] OFS_BHI   = 4'd8;
  localparam logic [REG_AW-1:0] OFS_BLO   = 4'd9;
  localparam logic [REG_AW-1:0] OFS_BDATA = 4'd10;

  typedef struct packed {
    logic abEn;
    logic fullMode;
    logic routeDbg;
    logic traceEn;
    logic loopMode;
    logic cEn;
    logic rwCmpEn;
    logic rwLevel;
    logic pageSel;
  } brkStb_t;

  typedef struct packed {
    logic [ADDR_W-1:0] aAddr;
    logic [ADDR_W-1:0] bAddr;
    logic [DATA_W-1:0] bData;
    logic [ADDR_W-1:0] cAddr;
    logic [EXT_W-1:0]  cExt;
  } brkCmp_t;
endpackage

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  output brkStb_t           stb,
  output brkCmp_t           cmp
);
  localparam int HI = ADDR_W - 1;
  localparam int LO_TOP = REG_DW - 1;

  brkStb_t stbQ;
  brkCmp_t cmpQ;

  wire armLoop = regWdata[0] && regWdata[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbQ <= '0;
      cmpQ <= '0;
    end else if (regWe) begin
      case (regAddr)
        OFS_AB: begin
          stbQ.abEn     <= regWdata[0];
          stbQ.fullMode <= regWdata[1];
          stbQ.routeDbg <= regWdata[2];
        end
        OFS_DBG: begin
          stbQ.loopMode <= regWdata[1];
          if (!stbQ.abEn) begin
            stbQ.traceEn <= regWdata[0];
            if (armLoop) cmpQ.cAddr <= '0;
          end
        end
        OFS_CCTL: begin
          stbQ.cEn     <= regWdata[0];
          stbQ.rwCmpEn <= regWdata[1];
          stbQ.rwLevel <= regWdata[2];
          stbQ.pageSel <= regWdata[3];
        end
        OFS_CHI:   cmpQ.cAddr[HI -: REG_DW]   <= regWdata;
        OFS_CLO:   cmpQ.cAddr[LO_TOP:0]       <= regWdata;
        OFS_CEXT:  cmpQ.cExt                  <= regWdata[EXT_W-1:0];
        OFS_AHI:   cmpQ.aAddr[HI -: REG_DW]   <= regWdata;
        OFS_ALO:   cmpQ.aAddr[LO_TOP:0]       <= regWdata;
        OFS_BHI:   cmpQ.bAddr[HI -: REG_DW]   <= regWdata;
        OFS_BLO:   cmpQ.bAddr[LO_TOP:0]       <= regWdata;
        OFS_BDATA: cmpQ.bData                 <= regWdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  assign stb = stbQ;
  assign cmp = cmpQ;
endmodule

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  brkStb_t           stb,
  input  brkCmp_t           cmp,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PAGE_W-1:0] busPage,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRw,
  output logic              brkSwi,
  output logic              brkDbg
);
  localparam int LOW_W = ADDR_W - 8;
  localparam int MID_W = 8 - (PAGE_W - EXT_W);

  logic aEq, bEq, dEq, abHit;
  logic cActive, cHiEq, cLoEq, cExtOk, cRwOk, cHit;
  logic hitNow, fire;
  logic [7:0] cHiBus;
  logic heldHit;
  logic [ADDR_W-1:0] lastAddr;

  always_comb begin
    aEq = (busAddr == cmp.aAddr);
    bEq = (busAddr == cmp.bAddr);
    dEq = (busData == cmp.bData);
    if (!stb.abEn)        abHit = 1'b0;
    else if (stb.fullMode) abHit = aEq && dEq;
    else                   abHit = aEq || bEq;
  end

  always_comb begin
    cActive = stb.cEn && (stb.abEn || (stb.traceEn && !stb.loopMode));
    if (stb.pageSel) begin
      cHiBus = {busPage[PAGE_W-EXT_W-1:0], busAddr[LOW_W+MID_W-1:LOW_W]};
      cExtOk = (busPage[PAGE_W-1 -: EXT_W] == cmp.cExt);
    end else begin
      cHiBus = busAddr[ADDR_W-1:LOW_W];
      cExtOk = 1'b1;
    end
    cHiEq = (cHiBus == cmp.cAddr[ADDR_W-1:LOW_W]);
    cLoEq = (busAddr[LOW_W-1:0] == cmp.cAddr[LOW_W-1:0]);
    cRwOk = !stb.rwCmpEn || (busRw == stb.rwLevel);
    cHit  = cActive && cHiEq && cLoEq && cExtOk && cRwOk;
  end

  always_comb begin
    hitNow = busValid && (abHit || cHit);
    fire   = hitNow && !(heldHit && (busAddr == lastAddr));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldHit  <= 1'b0;
      lastAddr <= '0;
      brkSwi   <= 1'b0;
      brkDbg   <= 1'b0;
    end else begin
      heldHit  <= hitNow;
      lastAddr <= busAddr;
      brkSwi   <= fire && !stb.routeDbg;
      brkDbg   <= fire && stb.routeDbg;
    end
  end
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PAGE_W-1:0] busPage,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRw,
  output logic              brkSwi,
  output logic              brkDbg
);
  brkStb_t ctrlStb;
  brkCmp_t ctrlCmp;

  brk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .stb(ctrlStb), .cmp(ctrlCmp)
  );

  brk_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .cmp(ctrlCmp),
    .busValid(busValid), .busAddr(busAddr), .busPage(busPage),
    .busData(busData), .busRw(busRw), .brkSwi(brkSwi), .brkDbg(brkDbg)
  );
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk
  import brk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [REG_AW-1:0] regAddr,
  input logic [REG_DW-1:0] regWdata,
  input logic              busValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic              brkSwi,
  input logic              brkDbg,
  input brkStb_t           stb,
  input brkCmp_t           cmp
);
  wire brkAny = brkSwi || brkDbg;

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rstN) !(brkSwi && brkDbg)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !busValid |=> !brkAny); // R10
  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    (brkAny && busValid && busAddr == $past(busAddr)) |=> !brkAny); // R10
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.abEn && !stb.cEn) |=> !brkAny); // R1
  AST_TRACE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (stb.abEn && !stb.traceEn) |=> !stb.traceEn); // R5
  AST_FULL_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (stb.abEn && stb.fullMode && !stb.cEn && busData != cmp.bData) |=> !brkAny); // R3
  AST_LOOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == OFS_DBG && regWdata[1:0] == 2'b11 && !stb.abEn) |=> (cmp.cAddr == '0)); // R9
endmodule

bind brk_unit brk_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .busValid(busValid), .busAddr(busAddr), .busData(busData),
  .brkSwi(brkSwi), .brkDbg(brkDbg), .stb(ctrlStb), .cmp(ctrlCmp)
);

// File: tb/brk_unit_bench.sv
module brk_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic busValid = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0] busPage = '0;
  logic [7:0] busData = '0;
  logic busRw = 1'b0;
  logic brkSwi, brkDbg;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit modelLive = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_unit u_brk_unit (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busValid(busValid), .busAddr(busAddr), .busPage(busPage), .busData(busData),
    .busRw(busRw), .brkSwi(brkSwi), .brkDbg(brkDbg)
  );

  // behavioural reference state
  bit mAb, mFull, mRoute, mTrace, mLoop, mCEn, mRwEn, mRwLvl, mPage;
  int mA, mB, mBData, mC, mExt;
  bit mHeld; int mLast;
  bit expSwi, expDbg;

  function automatic bit refHit();
    bit ab, c;
    int hiByte;
    ab = 0; c = 0;
    if (mAb) begin
      if (mFull) ab = (int'(busAddr) == mA) && (int'(busData) == mBData);
      else       ab = (int'(busAddr) == mA) || (int'(busAddr) == mB);
    end
    if (mCEn && (mAb || (mTrace && !mLoop))) begin
      hiByte = mPage ? (int'(busPage % 4) * 64 + int'(busAddr / 256) % 64) : int'(busAddr / 256);
      c = (hiByte == mC / 256) && (int'(busAddr % 256) == mC % 256);
      if (mPage && int'(busPage / 4) != mExt) c = 0;
      if (mRwEn && busRw != mRwLvl) c = 0;
    end
    return busValid && (ab || c);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      {mAb, mFull, mRoute, mTrace, mLoop, mCEn, mRwEn, mRwLvl, mPage} = '0;
      mA = 0; mB = 0; mBData = 0; mC = 0; mExt = 0;
      mHeld = 0; mLast = 0; expSwi = 0; expDbg = 0;
    end else begin
      bit h, f;
      h = refHit();
      f = h && !(mHeld && int'(busAddr) == mLast);
      expSwi = f && !mRoute;
      expDbg = f && mRoute;
      mHeld = h; mLast = int'(busAddr);
      if (regWe) begin
        case (regAddr)
          4'd0: begin mAb = regWdata[0]; mFull = regWdata[1]; mRoute = regWdata[2]; end
          4'd1: begin
            if (!mAb) begin
              mTrace = regWdata[0];
              if (regWdata[0] && regWdata[1]) mC = 0;
            end
            mLoop = regWdata[1];
          end
          4'd2: begin mCEn = regWdata[0]; mRwEn = regWdata[1]; mRwLvl = regWdata[2]; mPage = regWdata[3]; end
          4'd3: mC = (mC % 256) + int'(regWdata) * 256;
          4'd4: mC = (mC / 256) * 256 + int'(regWdata);
          4'd5: mExt = int'(regWdata) % 64;
          4'd6: mA = (mA % 256) + int'(regWdata) * 256;
          4'd7: mA = (mA / 256) * 256 + int'(regWdata);
          4'd8: mB = (mB % 256) + int'(regWdata) * 256;
          4'd9: mB = (mB / 256) * 256 + int'(regWdata);
          4'd10: mBData = int'(regWdata);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (modelLive && rstN) begin
      chk("MODEL swi", int'(brkSwi), int'(expSwi));
      chk("MODEL dbg", int'(brkDbg), int'(expDbg));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic cyc(input logic [15:0] a, input logic [7:0] pg, input logic [7:0] d,
                     input logic rw, input int eS, input int eD, input string tag);
    busValid = 1'b1; busAddr = a; busPage = pg; busData = d; busRw = rw;
    @(negedge clk);
    chk({tag, " swi"}, int'(brkSwi), eS);
    chk({tag, " dbg"}, int'(brkDbg), eD);
  endtask

  task automatic idle();
    busValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelLive = 1;
    @(negedge clk);
    chk("R11 reset swi", int'(brkSwi), 0);
    chk("R11 reset dbg", int'(brkDbg), 0);
    cyc(16'h0000, 8'h00, 8'h00, 1'b0, 0, 0, "R11 no break after reset");
    idle();

    wr(4'd6, 8'h12); wr(4'd7, 8'h34); wr(4'd8, 8'h40); wr(4'd9, 8'h00);
    wr(4'd0, 8'h02);
    cyc(16'h1234, 8'h00, 8'h00, 1'b0, 0, 0, "R1 disabled full");
    idle();

    wr(4'd0, 8'h01);
    cyc(16'h1234, 8'h00, 8'h00, 1'b0, 1, 0, "R2 A match"); idle();
    cyc(16'h4000, 8'h00, 8'h00, 1'b0, 1, 0, "R2 B match"); idle();
    cyc(16'h4001, 8'h00, 8'h00, 1'b0, 0, 0, "R2 miss"); idle();

    wr(4'd0, 8'h05);
    cyc(16'h4000, 8'h00, 8'h00, 1'b0, 0, 1, "R4 debug route"); idle();
    cyc(16'h4000, 8'h00, 8'h00, 1'b0, 0, 1, "R10 first");
    cyc(16'h4000, 8'h00, 8'h00, 1'b0, 0, 0, "R10 same address held");
    cyc(16'h1234, 8'h00, 8'h00, 1'b0, 0, 1, "R10 new address");
    busValid = 1'b0; busAddr = 16'h4000;
    @(negedge clk);
    chk("R10 invalid swi", int'(brkSwi), 0);
    chk("R10 invalid dbg", int'(brkDbg), 0);
    idle();

    wr(4'd10, 8'h5A); wr(4'd0, 8'h03);
    cyc(16'h1234, 8'h00, 8'h5A, 1'b0, 1, 0, "R3 addr and data"); idle();
    cyc(16'h1234, 8'h00, 8'h5B, 1'b0, 0, 0, "R3 data miss"); idle();
    cyc(16'h4000, 8'h00, 8'h5A, 1'b0, 0, 0, "R3 B addr ignored"); idle();

    wr(4'd0, 8'h01); wr(4'd1, 8'h01); wr(4'd0, 8'h00);
    wr(4'd3, 8'h20); wr(4'd4, 8'h00); wr(4'd2, 8'h01);
    cyc(16'h2000, 8'h00, 8'h00, 1'b0, 0, 0, "R5 trace write ignored"); idle();
    wr(4'd1, 8'h01);
    cyc(16'h2000, 8'h00, 8'h00, 1'b0, 1, 0, "R6 C in debug mode"); idle();
    cyc(16'h2001, 8'h00, 8'h00, 1'b0, 0, 0, "R6 C miss"); idle();
    wr(4'd0, 8'h04);
    cyc(16'h2000, 8'h00, 8'h00, 1'b0, 0, 1, "R6 C routed debug"); idle();

    wr(4'd2, 8'h07);
    cyc(16'h2000, 8'h00, 8'h00, 1'b0, 0, 0, "R8 wrong level"); idle();
    cyc(16'h2000, 8'h00, 8'h00, 1'b1, 0, 1, "R8 right level"); idle();

    wr(4'd5, 8'h15); wr(4'd3, 8'h80); wr(4'd4, 8'h00); wr(4'd2, 8'h09);
    cyc(16'h0000, 8'h56, 8'h00, 1'b0, 0, 1, "R7 page match"); idle();
    cyc(16'hC000, 8'h56, 8'h00, 1'b0, 0, 1, "R7 top bits replaced"); idle();
    cyc(16'h0000, 8'h52, 8'h00, 1'b0, 0, 0, "R7 ext miss"); idle();
    cyc(16'h0000, 8'h55, 8'h00, 1'b0, 0, 0, "R7 high byte miss"); idle();
    wr(4'd2, 8'h01);
    cyc(16'h8000, 8'h00, 8'h00, 1'b0, 0, 1, "R7 page compare off"); idle();

    wr(4'd1, 8'h03);
    cyc(16'h0000, 8'h00, 8'h00, 1'b0, 0, 0, "R6 loop mode blocks C"); idle();
    wr(4'd1, 8'h01);
    cyc(16'h8000, 8'h00, 8'h00, 1'b0, 0, 0, "R9 old value gone"); idle();
    cyc(16'h0000, 8'h00, 8'h00, 1'b0, 0, 1, "R9 cleared to zero"); idle();

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule